// File: doc/BRIEF.md
# Dual-Multiplier Adder with Loopback

This block forms two products from two operand pairs and combines them into one 36-bit result. Whether the second product is added to or subtracted from the first is fixed when the block is elaborated. Operand widths and signedness are also elaboration parameters. Any setting whose worst-case exact result could need more than 36 bits stops elaboration.

In loopback configuration, the second operand of multiplier 0 is not taken from its port. It comes instead from a register that holds the upper 18 bits of the most recent valid combined result. A per-sample control, `zero_lb_i`, can replace that fed-back operand with zero. This lets iterative structures such as recursive filter sections start from a clean state without a reset.

An optional round-and-saturate stage sits after the adder. Optional registers after the multipliers and at the output trade latency for clock rate. A valid flag tracks each accepted sample through whatever latency is configured.

Top module: `dual_mult_add`

## Requirements
- R1: With `SUBTRACT`=0 the combined result is p0+p1, and with `SUBTRACT`=1 it is p0-p1. p0 is a0×b0 (or a0 times the loopback operand) and p1 is a1×b1, both taken as 36-bit two's complement.
- R2: Elaboration fails when `A_W`+`B_W`+1 exceeds 36. Every accepted configuration gives the exact result, for example the full-scale unsigned 17×18 sum.
- R3: With `LOOPBACK`=1, multiplier 0 uses bits 35:18 of the previous valid combined result as its second operand, and `b0_i` has no effect. That operand is signed when `IS_SIGNED`=1.
- R4: A sample presented with `zero_lb_i`=1 uses zero in place of the fed-back operand. The control is sampled with each operand set.
- R5: The loopback register changes only when a valid combined result is produced, and it holds across idle cycles.
- R6: `valid_o` equals `en_i` delayed by exactly `PIPE_REG`+`OUT_REG` cycles (0, 1 or 2), and `result_o` is the matching sample in that same cycle.
- R7: With `RND_SAT`=1, the result is rounded half-up at bit `RND_BIT`: 2^(`RND_BIT`-1) is added, then the bits below `RND_BIT` are cleared.
- R8: With `RND_SAT`=1, a rounded value outside the `SAT_W`-bit range is clamped to the most positive or most negative value of that range. The range is signed or unsigned per `IS_SIGNED`, and the value is sign-extended onto 36 bits.
- R9: `ovf_o` sets when a valid sample is clamped and stays set until reset.
- R10: Reset (`rst_ni` low) clears every pipeline register, the loopback register, `result_o`, `valid_o` and `ovf_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Operand set valid this cycle |
| zero_lb_i | input | 1 | Use zero instead of the loopback operand |
| a0_i | input | A_W | First operand of multiplier 0 |
| b0_i | input | B_W | Second operand of multiplier 0 (unused in loopback) |
| a1_i | input | A_W | First operand of multiplier 1 |
| b1_i | input | B_W | Second operand of multiplier 1 |
| result_o | output | 36 | Combined, optionally rounded and clamped result |
| valid_o | output | 1 | result_o holds a sample |
| ovf_o | output | 1 | Sticky clamp indicator |

## Verification
Several properties are checked every cycle:
- the valid flag follows the enable at the configured latency;
- the overflow flag never falls outside reset;
- the loopback register holds while no valid sum is present;
- every valid rounded output lies on the rounding grid and inside the saturation range.

The exact arithmetic can only be shown by bench scenarios. That covers the sum versus difference, the half-up tie cases at both signs, rounding that pushes a value into the clamp, and the full-scale unsigned sum. The same applies to the feedback content: the signed upper half carried into the next sample, zeroing on demand, and loss of the fed-back value after reset.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int unsigned RES_W = 36;
  localparam int unsigned FB_W  = 18;
  typedef logic [RES_W-1:0] res_t;
endpackage

// File: rtl/dma_mult.sv
module dma_mult
  import dma_pkg::*;
#(
  parameter int unsigned A_W = 17,
  parameter int unsigned B_W = 18,
  parameter bit          SGN = 1'b1
) (
  input  logic [A_W-1:0] a_i,
  input  logic [B_W-1:0] b_i,
  output res_t           p_o
);
  res_t a_x, b_x;

  generate
    if (SGN) begin : g_sext
      assign a_x = {{(RES_W-A_W){a_i[A_W-1]}}, a_i};
      assign b_x = {{(RES_W-B_W){b_i[B_W-1]}}, b_i};
    end else begin : g_zext
      assign a_x = {{(RES_W-A_W){1'b0}}, a_i};
      assign b_x = {{(RES_W-B_W){1'b0}}, b_i};
    end
  endgenerate

  // modulo 2^36 product is exact because widths are checked at the top
  assign p_o = a_x * b_x;
endmodule

// File: rtl/dma_rnd_sat.sv
module dma_rnd_sat
  import dma_pkg::*;
#(
  parameter int unsigned RND_BIT = 4,
  parameter int unsigned SAT_W   = 36,
  parameter bit          SGN     = 1'b1
) (
  input  res_t s_i,
  output res_t r_o,
  output logic hit_o
);
  localparam int unsigned EXT_W = RES_W + 2;
  localparam logic [EXT_W-1:0] ONE    = EXT_W'(1);
  localparam logic [EXT_W-1:0] HALF   = ONE << (RND_BIT - 1);
  localparam logic [EXT_W-1:0] KEEP   = ~((ONE << RND_BIT) - ONE);
  localparam logic [EXT_W-1:0] LIM_HI = SGN ? (ONE << (SAT_W - 1)) - ONE
                                            : (ONE << SAT_W) - ONE;
  localparam logic [EXT_W-1:0] LIM_LO = SGN ? -(ONE << (SAT_W - 1)) : '0;

  logic [EXT_W-1:0] s_x, r_x, r_sel;
  logic             unused_ok;

  assign s_x = SGN ? {{2{s_i[RES_W-1]}}, s_i} : {2'b00, s_i};

  always_comb begin
    r_x   = (s_x + HALF) & KEEP;
    r_sel = r_x;
    hit_o = 1'b0;
    if ($signed(r_x) > $signed(LIM_HI)) begin
      r_sel = LIM_HI;
      hit_o = 1'b1;
    end else if ($signed(r_x) < $signed(LIM_LO)) begin
      r_sel = LIM_LO;
      hit_o = 1'b1;
    end
  end

  assign r_o       = r_sel[RES_W-1:0];
  assign unused_ok = ^r_sel[EXT_W-1:RES_W];
endmodule

// File: rtl/dual_mult_add.sv
module dual_mult_add
  import dma_pkg::*;
#(
  parameter int unsigned A_W       = 17,
  parameter int unsigned B_W       = 18,
  parameter bit          IS_SIGNED = 1'b1,
  parameter bit          SUBTRACT  = 1'b0,
  parameter bit          LOOPBACK  = 1'b1,
  parameter bit          PIPE_REG  = 1'b1,
  parameter bit          OUT_REG   = 1'b1,
  parameter bit          RND_SAT   = 1'b0,
  parameter int unsigned RND_BIT   = 4,
  parameter int unsigned SAT_W     = 36
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic           zero_lb_i,
  input  logic [A_W-1:0] a0_i,
  input  logic [B_W-1:0] b0_i,
  input  logic [A_W-1:0] a1_i,
  input  logic [B_W-1:0] b1_i,
  output res_t           result_o,
  output logic           valid_o,
  output logic           ovf_o
);
  localparam int unsigned NEED_W = A_W + B_W + 1;
  localparam int unsigned LAT    = 32'(PIPE_REG) + 32'(OUT_REG);

  generate
    if (NEED_W > RES_W) begin : g_bad_width
      $error("operand widths need %0d result bits, limit is %0d", NEED_W, RES_W);
    end
    if (LOOPBACK && B_W != FB_W) begin : g_bad_lb
      $error("loopback needs B_W == %0d", FB_W);
    end
    if (RND_BIT < 1 || RND_BIT > RES_W - 2) begin : g_bad_rnd
      $error("RND_BIT out of range");
    end
    if (SAT_W < 2 || SAT_W > RES_W || SAT_W <= RND_BIT) begin : g_bad_sat
      $error("SAT_W out of range");
    end
  endgenerate

  logic [B_W-1:0] b0_op;
  res_t           p0_c, p1_c, p0_s, p1_s, sum_c, rs_c;
  logic           v_s, hit_c, ovf_q;

  // ---------------- operand select ----------------
  generate
    if (LOOPBACK) begin : g_lb
      logic [FB_W-1:0] fb_q;
      logic            unused_ok;
      assign b0_op     = zero_lb_i ? '0 : B_W'(fb_q);
      assign unused_ok = ^b0_i;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  fb_q <= '0;
        else if (v_s) fb_q <= sum_c[RES_W-1 -: FB_W];
      end

      AST_FB_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !v_s |=> $stable(fb_q)); // R5
    end else begin : g_direct
      logic unused_ok;
      assign b0_op     = b0_i;
      assign unused_ok = zero_lb_i;
    end
  endgenerate

  dma_mult #(.A_W(A_W), .B_W(B_W), .SGN(IS_SIGNED)) u_mul0 (
    .a_i(a0_i), .b_i(b0_op), .p_o(p0_c)
  );
  dma_mult #(.A_W(A_W), .B_W(B_W), .SGN(IS_SIGNED)) u_mul1 (
    .a_i(a1_i), .b_i(b1_i), .p_o(p1_c)
  );

  // ---------------- product stage ----------------
  generate
    if (PIPE_REG) begin : g_pipe
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          p0_s <= '0;
          p1_s <= '0;
          v_s  <= 1'b0;
        end else begin
          v_s <= en_i;
          if (en_i) begin
            p0_s <= p0_c;
            p1_s <= p1_c;
          end
        end
      end
    end else begin : g_no_pipe
      assign p0_s = p0_c;
      assign p1_s = p1_c;
      assign v_s  = en_i;
    end
  endgenerate

  assign sum_c = SUBTRACT ? (p0_s - p1_s) : (p0_s + p1_s);

  // ---------------- round / saturate ----------------
  generate
    if (RND_SAT) begin : g_rs
      dma_rnd_sat #(.RND_BIT(RND_BIT), .SAT_W(SAT_W), .SGN(IS_SIGNED)) u_rs (
        .s_i(sum_c), .r_o(rs_c), .hit_o(hit_c)
      );
    end else begin : g_no_rs
      assign rs_c  = sum_c;
      assign hit_c = 1'b0;
    end
  endgenerate

  // ---------------- output stage ----------------
  generate
    if (OUT_REG) begin : g_out
      res_t res_q;
      logic v_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          res_q <= '0;
          v_q   <= 1'b0;
        end else begin
          v_q <= v_s;
          if (v_s) res_q <= rs_c;
        end
      end
      assign result_o = res_q;
      assign valid_o  = v_q;
    end else begin : g_no_out
      assign result_o = rs_c;
      assign valid_o  = v_s;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           ovf_q <= 1'b0;
    else if (v_s && hit_c) ovf_q <= 1'b1;
  end
  assign ovf_o = ovf_q;

  // ---------------- assertions ----------------
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o); // R9

  generate
    if (LAT > 0) begin : g_lat_chk
      AST_VALID_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_i |-> ##LAT valid_o); // R6
      AST_VALID_BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> $past(en_i, LAT)); // R6
    end
    if (RND_SAT) begin : g_rs_chk
      AST_RND_GRID: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> (result_o[RND_BIT-1:0] == '0) || (&result_o[RND_BIT-1:0])); // R7
      if (IS_SIGNED) begin : g_sgn_rng
        AST_SAT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
          valid_o |-> (&result_o[RES_W-1:SAT_W-1]) || !(|result_o[RES_W-1:SAT_W-1])); // R8
      end
    end
  endgenerate
endmodule

// File: tb/tb_dual_mult_add.sv
module tb_dual_mult_add;
  logic clk_i, rst_ni;
  int   checks, errors;

  // loopback instance: signed 17x18, add, latency 2
  logic        en_l, zl_l, val_l, ovf_l;
  logic [16:0] a0_l, a1_l;
  logic [17:0] b0_l, b1_l;
  logic [35:0] res_l;
  // normal instance: signed 16x16, subtract, round/sat, latency 1
  logic        en_n, val_n, ovf_n;
  logic [15:0] a0_n, b0_n, a1_n, b1_n;
  logic [35:0] res_n;
  // wide instance: unsigned 17x18, add, latency 0
  logic        en_w, val_w, ovf_w;
  logic [16:0] a0_w, a1_w;
  logic [17:0] b0_w, b1_w;
  logic [35:0] res_w;

  dual_mult_add #(.A_W(17), .B_W(18), .IS_SIGNED(1), .SUBTRACT(0), .LOOPBACK(1),
                  .PIPE_REG(1), .OUT_REG(1), .RND_SAT(0)) dut (
    .clk_i, .rst_ni, .en_i(en_l), .zero_lb_i(zl_l), .a0_i(a0_l), .b0_i(b0_l),
    .a1_i(a1_l), .b1_i(b1_l), .result_o(res_l), .valid_o(val_l), .ovf_o(ovf_l));

  dual_mult_add #(.A_W(16), .B_W(16), .IS_SIGNED(1), .SUBTRACT(1), .LOOPBACK(0),
                  .PIPE_REG(0), .OUT_REG(1), .RND_SAT(1), .RND_BIT(4), .SAT_W(24)) dut_n (
    .clk_i, .rst_ni, .en_i(en_n), .zero_lb_i(1'b0), .a0_i(a0_n), .b0_i(b0_n),
    .a1_i(a1_n), .b1_i(b1_n), .result_o(res_n), .valid_o(val_n), .ovf_o(ovf_n));

  dual_mult_add #(.A_W(17), .B_W(18), .IS_SIGNED(0), .SUBTRACT(0), .LOOPBACK(0),
                  .PIPE_REG(0), .OUT_REG(0), .RND_SAT(0)) dut_w (
    .clk_i, .rst_ni, .en_i(en_w), .zero_lb_i(1'b0), .a0_i(a0_w), .b0_i(b0_w),
    .a1_i(a1_w), .b1_i(b1_w), .result_o(res_w), .valid_o(val_w), .ovf_o(ovf_w));

  initial clk_i = 1'b0;
  always #5 clk_i = ~clk_i;

  // subtract, round half-up at bit 4, clamp to signed 24 bits
  localparam int    NV = 10;
  localparam int    VA0 [NV] = '{10, 1, 1, 0, 0, -100, 2896, 3000, 0, 4096};
  localparam int    VB0 [NV] = '{5, 8, 7, 0, 0, 50, 2896, 3000, 0, 2048};
  localparam int    VA1 [NV] = '{3, 0, 0, 1, 1, 20, 0, 0, 3000, 1};
  localparam int    VB1 [NV] = '{2, 0, 0, 8, 9, -30, 0, 0, 3000, 8};
  localparam longint VEX [NV] = '{48, 16, 0, 0, -16, -4400, 8386816, 8388607, -8388608, 8388607};
  localparam int    VOV [NV] = '{0, 0, 0, 0, 0, 0, 0, 1, 1, 1};

  function automatic logic [35:0] s36(input longint v);
    return v[35:0];
  endfunction

  function automatic string vtag(input int i);
    if (i == 0 || i == 5) return "R1";
    if (i < 5)            return "R7";
    return "R8";
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic lb_step(input string req, input bit zl, input int a0, input int a1,
                         input int b1, input longint exp);
    @(negedge clk_i);
    en_l = 1'b1; zl_l = zl;
    a0_l = 17'(a0); a1_l = 17'(a1); b1_l = 18'(b1);
    b0_l = 18'h2AAAA; // ignored in loopback (R3)
    @(negedge clk_i);
    en_l = 1'b0;
    chk("R6", 64'(val_l), 64'd0);
    @(negedge clk_i);
    chk("R6", 64'(val_l), 64'd1);
    chk(req, 64'(res_l), 64'(s36(exp)));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL R6 watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    rst_ni = 1'b0;
    en_l = 0; zl_l = 0; a0_l = '0; b0_l = '0; a1_l = '0; b1_l = '0;
    en_n = 0; a0_n = '0; b0_n = '0; a1_n = '0; b1_n = '0;
    en_w = 0; a0_w = '0; b0_w = '0; a1_w = '0; b1_w = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R10 reset state
    chk("R10", 64'(res_l), 64'd0);
    chk("R10", 64'(val_l), 64'd0);
    chk("R10", 64'(res_n), 64'd0);
    chk("R10", 64'(val_n), 64'd0);
    chk("R10", 64'(ovf_n), 64'd0);

    // wide unsigned, zero latency
    @(negedge clk_i);
    en_w = 1'b1; a0_w = 17'd3; b0_w = 18'd4; a1_w = 17'd5; b1_w = 18'd6;
    #1;
    chk("R6", 64'(val_w), 64'd1);
    chk("R1", 64'(res_w), 64'd42);
    a0_w = 17'h1FFFF; b0_w = 18'h3FFFF; a1_w = 17'h1FFFF; b1_w = 18'h3FFFF;
    #1;
    chk("R2", 64'(res_w), 64'(longint'(131071) * 262143 * 2));
    chk("R2", 64'(ovf_w), 64'd0);
    en_w = 1'b0;
    #1;
    chk("R6", 64'(val_w), 64'd0);

    // vector table on the subtract / round / saturate instance
    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      en_n = 1'b1;
      a0_n = 16'(VA0[i]); b0_n = 16'(VB0[i]); a1_n = 16'(VA1[i]); b1_n = 16'(VB1[i]);
      @(negedge clk_i);
      en_n = 1'b0;
      chk("R6", 64'(val_n), 64'd1);
      chk(vtag(i), 64'(res_n), 64'(s36(VEX[i])));
      chk("R9", 64'(ovf_n), 64'(VOV[i]));
    end
    // R9 sticky across an unclamped sample
    @(negedge clk_i);
    en_n = 1'b1; a0_n = 16'd10; b0_n = 16'd5; a1_n = 16'd3; b1_n = 16'd2;
    @(negedge clk_i);
    en_n = 1'b0;
    chk("R1", 64'(res_n), 64'd48);
    chk("R9", 64'(ovf_n), 64'd1);

    // loopback sequence
    lb_step("R3", 1'b0, 5, 100, 3000, 300000);      // feedback starts at zero
    lb_step("R3", 1'b0, 7, 100, 3000, 300007);      // 7 * (300000 >> 18)
    lb_step("R4", 1'b1, 7, 0, 0, 0);                // feedback 1 zeroed
    lb_step("R3", 1'b0, 7, 0, 0, 0);                // feedback from zero sum
    lb_step("R3", 1'b0, 7, -100, 3000, -300000);    // feedback becomes -2
    repeat (3) @(negedge clk_i);
    lb_step("R5", 1'b0, 7, 0, 0, -14);              // held through idle, signed

    // R10 mid-run reset clears loopback and sticky flag
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    chk("R10", 64'(ovf_n), 64'd0);
    chk("R10", 64'(val_l), 64'd0);
    chk("R10", 64'(res_l), 64'd0);
    lb_step("R10", 1'b0, 7, 0, 0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule